// File: doc/BRIEF.md
# Route-Trace Packet Anomaly Classifier

This block decides whether a packet that crossed an on-chip router network took a legitimate route. For each packet, the router gathers a route trace into a packed feature word: the sending core, the receiving core, the five hop identifiers along the path, and the hop distance. The block computes a linear decision score in fixed point. The score is the bias plus the sum of each feature field times its signed weight. The score's sign then becomes a one-bit verdict. A verdict of 1 enables the destination core. A verdict of 0 flags the packet as anomalous, so the sender drops it and starts the transfer again.

The work is split into three registered stages. Stage one cuts the feature word into fields and zero-extends each field. Stage two multiplies the fields by the weights and accumulates them onto the bias. Stage three turns the sign of the score into the verdict. A valid flag travels with each word, and a new word may arrive on every cycle. Trained weights and the bias reach the block through a small write port. That port is one address for each weight plus one address for the bias, and it can be written while packets are in flight.

Top module: `route_anomaly_svm`

## Requirements
- R1: After reset, outValid and destEnable are 0, and all weights and the bias are 0, so the first packet classified without any writes gives destEnable = 1.
- R2: Feature fields in featWord, all unsigned and zero-extended to 6 bits: source core [3:0], destination core [7:4], hop 0 [10:8], hop 1 [13:11], hop 2 [16:14], hop 3 [19:17], hop 4 [22:20], distance [26:23]; weight index i belongs to the field listed i-th here, starting at 0.
- R3: The score is bias + sum over i of weight[i] * field[i], with weights and bias as 6-bit two's complement values; the accumulator is wide enough that no combination of weights, bias and fields wraps the sign.
- R4: A score below zero gives destEnable = 0 (anomaly); a score of zero or above gives destEnable = 1.
- R5: A word sampled with featValid high at clock edge k yields outValid high in the cycle following edge k+2, exactly once; words on consecutive cycles yield results on consecutive cycles in the same order.
- R6: destEnable is 0 in every cycle in which outValid is 0.
- R7: A write with wrEn high stores wrData as weight[wrAddr] for wrAddr 0 to 7, and as the bias for wrAddr 8.
- R8: A write with wrAddr from 9 to 15 changes no weight and not the bias.
- R9: A write sampled at the same edge as a feature word takes part in that word's score; a write sampled one edge later does not.
- R10: Cycles with featValid low produce no result, and the gaps between results match the gaps between input words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| featValid | input | 1 | featWord holds a packet's route trace this cycle |
| featWord | input | 27 | Packed route-trace feature word |
| wrEn | input | 1 | Coefficient write strobe |
| wrAddr | input | 4 | Coefficient select: 0 to 7 weights, 8 bias |
| wrData | input | 6 | Signed coefficient value |
| outValid | output | 1 | Verdict present this cycle |
| destEnable | output | 1 | 1 = normal packet, 0 = anomaly |

## Verification
The two functions that can meet in one cycle are a coefficient write and the acceptance of a feature word. The timing of the write decides which score sees the new coefficient. The bench drives a weight or bias write on the same edge as a word, and also one edge after a word. Each of those words sits right at the sign boundary, so only the correct choice of coefficient gives the expected verdict. A scoreboard model applies a write before it computes the score of a word that shares the write's edge. It checks each verdict against that model and against the cycle in which the verdict is due.

// File: rtl/route_anomaly_svm_pkg.sv
package route_anomaly_svm_pkg;

  // Configuration: eight route-trace features, 6-bit signed coefficients.
  localparam int NUM_FEAT = 8;
  localparam int WEIGHT_W = 6;
  // Field widths packed 4 bits each, feature 0 in the lowest nibble.
  localparam logic [31:0] FIELD_W_VEC = 32'h4333_3344;

  function automatic int fieldWidth(input int idx);
    return int'(FIELD_W_VEC[4*idx +: 4]);
  endfunction

  function automatic int fieldLsb(input int idx);
    int pos;
    pos = 0;
    for (int k = 0; k < idx; k++) pos += fieldWidth(k);
    return pos;
  endfunction

  localparam int WORD_W = fieldLsb(NUM_FEAT);
  localparam int IDX_W  = $clog2(NUM_FEAT);
  localparam int ADDR_W = $clog2(NUM_FEAT + 1);
  localparam int PROD_W = 2 * WEIGHT_W + 1;
  localparam int ACC_W  = PROD_W + $clog2(NUM_FEAT + 1);

  typedef struct packed {
    logic             s1Load;
    logic             s2Load;
    logic             s3Load;
    logic             wrWeight;
    logic             wrBias;
    logic [IDX_W-1:0] wrIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/route_anomaly_svm_ctrl.sv
module route_anomaly_svm_ctrl
  import route_anomaly_svm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              featValid,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctrlStrobe_t       strb,
  output logic              outValid
);

  logic s1Valid;
  logic s2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s2Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= featValid;
      s2Valid  <= s1Valid;
      outValid <= s2Valid;
    end
  end

  always_comb begin
    strb.s1Load   = featValid;
    strb.s2Load   = s1Valid;
    strb.s3Load   = s2Valid;
    strb.wrWeight = wrEn && (wrAddr < ADDR_W'(NUM_FEAT));
    strb.wrBias   = wrEn && (wrAddr == ADDR_W'(NUM_FEAT));
    strb.wrIdx    = wrAddr[IDX_W-1:0];
  end

  // R7: one coefficient register at most per write
  p_single_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrWeight, strb.wrBias}));

  // R8: out-of-range addresses raise no write strobe
  p_ignore_high_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > ADDR_W'(NUM_FEAT)) |-> !(strb.wrWeight || strb.wrBias));

endmodule

// File: rtl/route_anomaly_svm_dp.sv
module route_anomaly_svm_dp
  import route_anomaly_svm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [WORD_W-1:0]   featWord,
  input  logic [WEIGHT_W-1:0] wrData,
  output logic                classBit
);

  logic        [WEIGHT_W-1:0] featReg   [NUM_FEAT];
  logic signed [WEIGHT_W-1:0] weightReg [NUM_FEAT];
  logic signed [WEIGHT_W-1:0] biasReg;
  logic signed [ACC_W-1:0]    termArr   [NUM_FEAT];
  logic signed [ACC_W-1:0]    macSum;
  logic signed [ACC_W-1:0]    scoreReg;
  logic                       featZero;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FEAT; gi++) begin : g_feat
      localparam int FW  = fieldWidth(gi);
      localparam int LSB = fieldLsb(gi);
      logic [WEIGHT_W-1:0] fieldExt;
      assign fieldExt = WEIGHT_W'(featWord[LSB +: FW]);

      // Stage 1: field extraction
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            featReg[gi] <= '0;
        else if (strb.s1Load) featReg[gi] <= fieldExt;
      end

      // Coefficient storage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) weightReg[gi] <= '0;
        else if (strb.wrWeight && strb.wrIdx == IDX_W'(gi))
          weightReg[gi] <= $signed(wrData);
      end

      assign termArr[gi] = ACC_W'(weightReg[gi]) * ACC_W'($signed({1'b0, featReg[gi]}));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            biasReg <= '0;
    else if (strb.wrBias) biasReg <= $signed(wrData);
  end

  always_comb begin
    macSum = ACC_W'(biasReg);
    for (int i = 0; i < NUM_FEAT; i++) macSum = macSum + termArr[i];
  end

  // Stage 2: score register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            scoreReg <= '0;
    else if (strb.s2Load) scoreReg <= macSum;
  end

  // Stage 3: sign to verdict, cleared between results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) classBit <= 1'b0;
    else       classBit <= strb.s3Load ? !scoreReg[ACC_W-1] : 1'b0;
  end

  always_comb begin
    featZero = 1'b1;
    for (int i = 0; i < NUM_FEAT; i++) featZero = featZero && (featReg[i] == '0);
  end

  // R3: an all-zero trace scores exactly the bias in force
  p_bias_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && featZero) |=> (scoreReg == ACC_W'($past(biasReg))));

  // R4: the verdict follows the sign of the registered score
  p_sign_verdict_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.s3Load |=> (classBit == ($past(scoreReg) >= 0)));

endmodule

// File: rtl/route_anomaly_svm.sv
module route_anomaly_svm
  import route_anomaly_svm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                featValid,
  input  logic [WORD_W-1:0]   featWord,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [WEIGHT_W-1:0] wrData,
  output logic                outValid,
  output logic                destEnable
);

  ctrlStrobe_t strb;
  logic        classBit;

  route_anomaly_svm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .featValid (featValid),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .strb      (strb),
    .outValid  (outValid)
  );

  route_anomaly_svm_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .featWord (featWord),
    .wrData   (wrData),
    .classBit (classBit)
  );

  assign destEnable = classBit;

  // Cycles since reset, saturating, so latency checks never look before reset
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  // R5: each accepted word yields one verdict three edges later
  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd3) |-> (outValid == $past(featValid, 3)));

  // R6: no enable without a verdict
  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !destEnable);

endmodule

// File: tb/tb_route_anomaly_svm.sv
module tb_route_anomaly_svm;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        featValid = 1'b0;
  logic [26:0] featWord = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [5:0]  wrData = '0;
  logic        outValid;
  logic        destEnable;

  route_anomaly_svm dut (
    .clk(clk), .rstN(rstN), .featValid(featValid), .featWord(featWord),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .destEnable(destEnable)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    bit    expEn;
    int    due;
    int    score;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  int mW[8];
  int mB;
  int fw[8] = '{4, 4, 3, 3, 3, 3, 3, 4};

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int fLsb(int idx);
    int p = 0;
    for (int k = 0; k < idx; k++) p += fw[k];
    return p;
  endfunction

  function automatic int getField(logic [26:0] w, int idx);
    return int'((w >> fLsb(idx)) & ((27'd1 << fw[idx]) - 27'd1));
  endfunction

  function automatic logic [26:0] setField(logic [26:0] w, int idx, int v);
    logic [26:0] m;
    m = ((27'd1 << fw[idx]) - 27'd1) << fLsb(idx);
    return (w & ~m) | ((27'(v) << fLsb(idx)) & m);
  endfunction

  function automatic int fmax(int idx);
    return (1 << fw[idx]) - 1;
  endfunction

  function automatic logic [26:0] allMax();
    logic [26:0] w = '0;
    for (int k = 0; k < 8; k++) w = setField(w, k, fmax(k));
    return w;
  endfunction

  function automatic int modelScore(logic [26:0] w);
    int s = mB;
    for (int k = 0; k < 8; k++) s += mW[k] * getField(w, k);
    return s;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: one cycle of stimulus; model writes land before the score of a same-edge word (R9)
  task automatic step(bit v, logic [26:0] w, bit we, int a, int d, string tag);
    item_t it;
    featValid = v; featWord = w;
    wrEn = we; wrAddr = 4'(a); wrData = 6'(d);
    if (we) begin
      if (a < 8)       mW[a] = d;
      else if (a == 8) mB = d;
    end
    if (v) begin
      it.score = modelScore(w);
      it.expEn = (it.score >= 0);
      it.due   = cyc + 3;
      it.tag   = tag;
      q.push_back(it);
    end
    @(negedge clk);
    featValid = 1'b0; wrEn = 1'b0;
  endtask

  task automatic wr(int a, int d);
    step(1'b0, '0, 1'b1, a, d, "");
  endtask

  task automatic pkt(logic [26:0] w, string tag);
    step(1'b1, w, 1'b0, 0, 0, tag);
  endtask

  task automatic clearAll();
    for (int k = 0; k < 9; k++) wr(k, 0);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (outValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected verdict", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(destEnable == it.expEn, it.tag, int'(destEnable), int'(it.expEn));
          check(cyc == it.due, "R5 verdict cycle", cyc, it.due);
        end
      end else begin
        check(destEnable == 1'b0, "R6 enable while idle", int'(destEnable), 0);
      end
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) mW[k] = 0;
    mB = 0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    check(destEnable == 1'b0, "R1 destEnable in reset", int'(destEnable), 0);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);

    // R1: zero coefficients give score 0, i.e. normal
    pkt(allMax(), "R1 default coefficients");
    idle(4);

    // R2 and R7: each field reaches its own weight
    for (int i = 0; i < 8; i++) begin
      clearAll();
      wr(i, -1);
      pkt(setField(allMax(), i, 0), "R2 field zero");
      pkt(setField(allMax(), i, 1), "R2 field one");
      pkt(setField('0, i, fmax(i)), "R7 field max");
    end

    // R4: boundary around zero
    clearAll();
    wr(8, 5); wr(0, -1);
    pkt(setField('0, 0, 5), "R4 score zero");
    pkt(setField('0, 0, 6), "R4 score minus one");
    pkt(setField('0, 0, 4), "R4 score plus one");

    // R3: extremes, no wrap
    for (int k = 0; k < 8; k++) wr(k, 31);
    wr(8, 31);
    pkt(allMax(), "R3 max positive");
    for (int k = 0; k < 8; k++) wr(k, -32);
    wr(8, -32);
    pkt(allMax(), "R3 max negative");
    wr(8, 31);
    pkt('0, "R3 bias only");
    for (int k = 0; k < 8; k++) wr(k, (k % 2 == 0) ? 7 : -9);
    wr(8, -3);

    // R5: back-to-back stream
    for (int n = 0; n < 24; n++) pkt(27'((n * 32'h9E3779B1) >> 5), "R5 streamed word");
    // R10: gapped stream
    for (int n = 0; n < 10; n++) begin
      pkt(27'((n * 32'h85EBCA6B) >> 3), "R10 gapped word");
      idle(n % 3);
    end
    idle(4);

    // R8: high addresses ignored
    clearAll();
    wr(8, 1); wr(1, -1);
    for (int a = 9; a < 16; a++) wr(a, -32);
    pkt(setField('0, 1, 1), "R8 after ignored writes");
    pkt(allMax(), "R8 after ignored writes");

    // R9: write on the same edge as a word applies; one edge later does not
    clearAll();
    step(1'b1, setField('0, 0, 1), 1'b1, 0, -1, "R9 same-edge weight");
    step(1'b1, setField('0, 0, 1), 1'b1, 8, 1, "R9 same-edge bias");
    pkt(setField('0, 0, 2), "R9 word before late write");
    wr(8, 3);
    pkt(setField('0, 0, 2), "R9 word after late write");

    idle(6);
    check(q.size() == 0, "R5 pending verdicts", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule